// File: doc/BRIEF.md
# Flash Write Controller With Completion Polling

This block sits on the host side of a parallel NOR-style flash bus and carries out one write operation per request. A request names one of four operations: byte program, sector erase, block erase or whole-chip erase. It also carries a target address, a data byte and a polling mode. The controller emits the unlock write sequence that the flash expects, then reads the target location repeatedly until the status bits show the internal operation has ended.

Bus timing is reduced to one access slot of `SLOT_CYC` clock cycles. Address and write data are held for the whole slot. The commit cycle is marked by a one-cycle strobe in the last cycle of the slot: `fl_we` for a write, `fl_re` for a read. Read data is taken in that same cycle. The flash may finish its work at any moment relative to the polling reads, so a single good-looking status read is not trusted. Completion is declared only when that read is followed by two further consistent reads. A cycle budget bounds each operation. When the budget runs out, a reset command is written to the flash and the request finishes with an error.

Top module: `flash_wr_ctrl`

## Requirements
- R1: A program request (`op`=0) commits exactly four writes, as (address, data): (5555h, AAh), (2AAAh, 55h), (5555h, A0h), (`addr`, `wdata`).
- R2: An erase request commits exactly six writes: (5555h, AAh), (2AAAh, 55h), (5555h, 80h), (5555h, AAh), (2AAAh, 55h), then a final write chosen by `op`. For sector erase (`op`=1) it is (`addr`, 30h), for block erase (`op`=2) it is (`addr`, 50h), and for chip erase (`op`=3) it is (5555h, 10h).
- R3: No read strobe occurs before the last write of the sequence. Every polling read uses `addr`. `fl_we` and `fl_re` are never high together, and both stay low while idle.
- R4: In data-polling mode (`mode`=0), a read is good when its bit 7 equals bit 7 of `wdata` for a program, or equals 1 for any erase.
- R5: In toggle mode (`mode`=1), a read is good when its bit 6 equals bit 6 of the previous read of the same polling phase. The first read of the phase is never good.
- R6: Completion requires three good reads in a row. Any read that is not good restarts the count, so a lone good read during the busy phase does not end the operation.
- R7: On completion, `done` is high for exactly one cycle with `err` low, and `rd_value` holds the last polled byte.
- R8: Polling ends by timeout at the read that ends in polling cycle `PROG_TO_CYC`-1 for a program, or `ERASE_TO_CYC`-1 for an erase; the limits are multiples of `SLOT_CYC`. One write (5555h, F0h) then follows, and then `done` and `err` pulse together.
- R9: `busy` is high from the cycle after an accepted `start` until `done`. A `start` seen while busy is ignored.
- R10: While reset is held and right after it, `busy`, `done`, `err`, `fl_we` and `fl_re` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, accepted when not busy |
| op | input | 2 | 0 program, 1 sector erase, 2 block erase, 3 chip erase |
| mode | input | 1 | 0 data-bit polling, 1 toggle-bit polling |
| addr | input | AW | Target address |
| wdata | input | 8 | Byte to program |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Timeout flag, valid with done |
| rd_value | output | 8 | Last byte read while polling |
| fl_we | output | 1 | Write commit strobe |
| fl_re | output | 1 | Read sample strobe |
| fl_addr | output | AW | Flash address |
| fl_wdata | output | 8 | Flash write data |
| fl_rdata | input | 8 | Flash read data |

## Verification
The checker watches the bus and handshake properties on every cycle. These are the exclusive strobes, a quiet bus while idle, `done` being a single-cycle pulse that never meets `busy`, `err` appearing only with `done`, and `busy` rising after an accepted start. The exact unlock sequences, the choice of final erase command, and the good-read rules of both polling modes can only be shown by the bench's scenarios. The same holds for rejecting a lone spurious good read, the number of reads before completion or timeout, and the trailing reset write. A flash model in the bench produces status bytes for a set number of busy reads and can inject one spurious true read.

// File: rtl/flash_wr_ctrl.sv
module flash_wr_ctrl #(
  parameter int AW           = 20,
  parameter int SLOT_CYC     = 2,
  parameter int PROG_TO_CYC  = 2000,
  parameter int ERASE_TO_CYC = 2000000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    op,
  input  logic          mode,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [7:0]    rd_value,
  output logic          fl_we,
  output logic          fl_re,
  output logic [AW-1:0] fl_addr,
  output logic [7:0]    fl_wdata,
  input  logic [7:0]    fl_rdata
);
  localparam int SCW   = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1;
  localparam int MAXTO = (PROG_TO_CYC > ERASE_TO_CYC) ? PROG_TO_CYC : ERASE_TO_CYC;
  localparam int TOW   = $clog2(MAXTO + 1);
  localparam logic [1:0] OP_PROG = 2'd0, OP_SECT = 2'd1, OP_BLK = 2'd2;
  localparam logic [AW-1:0] A_5555 = AW'(16'h5555), A_2AAA = AW'(16'h2AAA);

  typedef enum logic [1:0] {S_IDLE, S_WR, S_POLL, S_EXIT} st_t;

  st_t            st;
  logic [SCW-1:0] sc;
  logic [2:0]     step;
  logic [1:0]     op_q;
  logic           mode_q;
  logic [AW-1:0]  addr_q;
  logic [7:0]     data_q;
  logic [TOW-1:0] to_cnt;
  logic [1:0]     okc;
  logic           prev6, have_prev;
  logic [7:0]     rdv;
  logic           done_q, err_q;

  wire is_prog  = (op_q == OP_PROG);
  wire slot_end = (sc == SCW'(SLOT_CYC - 1));
  wire [2:0] last_step = is_prog ? 3'd3 : 3'd5;
  wire [TOW-1:0] to_lim = is_prog ? TOW'(PROG_TO_CYC - 1) : TOW'(ERASE_TO_CYC - 1);
  wire exp7     = is_prog ? data_q[7] : 1'b1;
  wire good     = mode_q ? (have_prev && (fl_rdata[6] == prev6)) : (fl_rdata[7] == exp7);
  wire finish   = good && (okc == 2'd2);
  wire timeout  = (to_cnt >= to_lim);

  assign busy     = (st != S_IDLE);
  assign done     = done_q;
  assign err      = err_q;
  assign rd_value = rdv;
  assign fl_we    = slot_end && ((st == S_WR) || (st == S_EXIT));
  assign fl_re    = slot_end && (st == S_POLL);

  always_comb begin
    fl_addr  = addr_q;
    fl_wdata = 8'h00;
    if (st == S_EXIT) begin
      fl_addr  = A_5555;
      fl_wdata = 8'hF0;
    end else if (st == S_WR) begin
      case (step)
        3'd0, 3'd3: begin
          if (step == 3'd3 && is_prog) begin
            fl_addr  = addr_q;
            fl_wdata = data_q;
          end else begin
            fl_addr  = A_5555;
            fl_wdata = 8'hAA;
          end
        end
        3'd1, 3'd4: begin
          fl_addr  = A_2AAA;
          fl_wdata = 8'h55;
        end
        3'd2: begin
          fl_addr  = A_5555;
          fl_wdata = is_prog ? 8'hA0 : 8'h80;
        end
        default: begin
          case (op_q)
            OP_SECT: begin fl_addr = addr_q; fl_wdata = 8'h30; end
            OP_BLK:  begin fl_addr = addr_q; fl_wdata = 8'h50; end
            default: begin fl_addr = A_5555; fl_wdata = 8'h10; end
          endcase
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      sc        <= '0;
      step      <= '0;
      op_q      <= '0;
      mode_q    <= 1'b0;
      addr_q    <= '0;
      data_q    <= '0;
      to_cnt    <= '0;
      okc       <= '0;
      prev6     <= 1'b0;
      have_prev <= 1'b0;
      rdv       <= '0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st     <= S_WR;
          sc     <= '0;
          step   <= '0;
          op_q   <= op;
          mode_q <= mode;
          addr_q <= addr;
          data_q <= wdata;
        end
        S_WR: if (slot_end) begin
          sc <= '0;
          if (step == last_step) begin
            st        <= S_POLL;
            to_cnt    <= '0;
            okc       <= '0;
            have_prev <= 1'b0;
          end else begin
            step <= step + 3'd1;
          end
        end else begin
          sc <= sc + 1'b1;
        end
        S_POLL: begin
          to_cnt <= to_cnt + 1'b1;
          if (slot_end) begin
            sc        <= '0;
            rdv       <= fl_rdata;
            prev6     <= fl_rdata[6];
            have_prev <= 1'b1;
            okc       <= good ? okc + 2'd1 : 2'd0;
            if (finish) begin
              st     <= S_IDLE;
              done_q <= 1'b1;
            end else if (timeout) begin
              st <= S_EXIT;
            end
          end else begin
            sc <= sc + 1'b1;
          end
        end
        default: if (slot_end) begin
          sc     <= '0;
          st     <= S_IDLE;
          done_q <= 1'b1;
          err_q  <= 1'b1;
        end else begin
          sc <= sc + 1'b1;
        end
      endcase
    end
  end
endmodule

module flash_wr_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic err,
  input logic fl_we,
  input logic fl_re
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(fl_we && fl_re)); // R3
  AST_IDLE_QUIET:  assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (!fl_we && !fl_re)); // R3
  AST_DONE_PULSE:  assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R7
  AST_DONE_IDLE:   assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R9
  AST_ERR_DONE:    assert property (@(posedge clk) disable iff (!rst_n) err |-> done); // R8
  AST_START_BUSY:  assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy); // R9
endmodule

bind flash_wr_ctrl flash_wr_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .err(err), .fl_we(fl_we), .fl_re(fl_re)
);

// File: tb/flash_wr_ctrl_tb.sv
module flash_wr_ctrl_tb_top;
  localparam int AW = 20, SLOT = 2, PT = 200, ET = 400;

  typedef struct packed {
    logic [1:0]  op;
    logic        mode;
    logic [19:0] adr;
    logic [7:0]  dat;
    logic [7:0]  bsy;
    logic [7:0]  glt;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 1'b0, 20'h12345, 8'hA5, 8'd5,   8'd255},
    '{2'd0, 1'b0, 20'h00010, 8'h3C, 8'd0,   8'd255},
    '{2'd1, 1'b0, 20'h43000, 8'h00, 8'd7,   8'd255},
    '{2'd2, 1'b1, 20'h70000, 8'h00, 8'd6,   8'd255},
    '{2'd3, 1'b1, 20'h00000, 8'h00, 8'd3,   8'd255},
    '{2'd0, 1'b1, 20'hABCDE, 8'h40, 8'd4,   8'd255},
    '{2'd0, 1'b0, 20'h00F00, 8'h81, 8'd6,   8'd2},
    '{2'd1, 1'b0, 20'h21000, 8'h00, 8'd10,  8'd9},
    '{2'd2, 1'b1, 20'h30000, 8'h00, 8'd255, 8'd255},
    '{2'd0, 1'b0, 20'h55AA5, 8'h12, 8'd255, 8'd255}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, mode = 1'b0;
  logic [1:0] op = '0;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic busy, done, err, fl_we, fl_re;
  logic [7:0] rd_value, fl_wdata, fl_rdata;
  logic [AW-1:0] fl_addr;

  int checks = 0, fails = 0;
  bit finished = 0;
  int wcnt = 0, rcnt = 0, wbase = 0, rbase = 0, first_rd_w = -1;
  logic [AW-1:0] wlog_a [64];
  logic [7:0]    wlog_d [64];
  logic [AW-1:0] rd_addr_last;
  vec_t cur;

  always #5 clk = ~clk;

  flash_wr_ctrl #(.AW(AW), .SLOT_CYC(SLOT), .PROG_TO_CYC(PT), .ERASE_TO_CYC(ET)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .mode(mode), .addr(addr),
    .wdata(wdata), .busy(busy), .done(done), .err(err), .rd_value(rd_value),
    .fl_we(fl_we), .fl_re(fl_re), .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_rdata(fl_rdata)
  );

  function automatic logic [7:0] mval(vec_t v, int n);
    logic [7:0] t;
    t = (v.op == 2'd0) ? v.dat : 8'hFF;
    if (n >= int'(v.bsy) || n == int'(v.glt)) return t;
    return {(v.op == 2'd0) ? ~v.dat[7] : 1'b0, n[0], 6'b0};
  endfunction

  assign fl_rdata = mval(cur, rcnt - rbase);

  always @(posedge clk) begin
    if (fl_we) begin
      if (wcnt < 64) begin
        wlog_a[wcnt] = fl_addr;
        wlog_d[wcnt] = fl_wdata;
      end
      wcnt++;
    end
    if (fl_re) begin
      if (rcnt == rbase) first_rd_w = wcnt - wbase;
      rd_addr_last = fl_addr;
      rcnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // expected read count and error from R4, R5, R6, R8
  task automatic expect_reads(input vec_t v, output int nr, output bit e);
    int lim, okc, p6;
    bit good;
    logic [7:0] x;
    lim = ((v.op == 2'd0) ? PT : ET) / SLOT;
    okc = 0; p6 = -1; e = 1'b1; nr = lim;
    for (int n = 0; n < lim; n++) begin
      x = mval(v, n);
      if (v.mode) good = (p6 >= 0) && (int'(x[6]) == p6);
      else good = (x[7] == ((v.op == 2'd0) ? v.dat[7] : 1'b1));
      p6 = int'(x[6]);
      okc = good ? okc + 1 : 0;
      if (okc == 3) begin nr = n + 1; e = 1'b0; break; end
    end
  endtask

  function automatic logic [AW-1:0] ewa(vec_t v, int k);
    if (v.op == 2'd0 && k == 3) return v.adr;
    if (k == 1 || k == 4) return AW'(16'h2AAA);
    if (k == 5 && v.op != 2'd3) return v.adr;
    return AW'(16'h5555);
  endfunction

  function automatic logic [7:0] ewd(vec_t v, int k);
    if (v.op == 2'd0) return (k == 0) ? 8'hAA : (k == 1) ? 8'h55 : (k == 2) ? 8'hA0 : v.dat;
    case (k)
      0, 3: return 8'hAA;
      1, 4: return 8'h55;
      2:    return 8'h80;
      default: return (v.op == 2'd1) ? 8'h30 : (v.op == 2'd2) ? 8'h50 : 8'h10;
    endcase
  endfunction

  task automatic run(input vec_t v, input bit poke);
    int nr, nw, n, ndone;
    bit e;
    string rq;
    @(negedge clk);
    cur = v; wbase = wcnt; rbase = rcnt; first_rd_w = -1;
    op = v.op; mode = v.mode; addr = v.adr; wdata = v.dat; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R9", "busy after start", busy, 1);
    n = 0; ndone = 0;
    while (!done && n < 20000) begin
      if (poke && n == 3) begin op = 2'd3; addr = 20'h0F0F0; start = 1'b1; end
      else start = 1'b0;
      @(negedge clk); n++;
    end
    start = 1'b0;
    expect_reads(v, nr, e);
    nw = (v.op == 2'd0) ? 4 : 6;
    rq = (v.op == 2'd0) ? "R1" : "R2";
    chk(done === 1'b1, "R7", "done seen", done, 1);
    chk(err === e, e ? "R8" : "R7", "err", err, e);
    chk(wcnt - wbase == nw + (e ? 1 : 0), rq, "write count", wcnt - wbase, nw + (e ? 1 : 0));
    for (int k = 0; k < nw; k++)
      chk(wlog_a[wbase+k] == ewa(v, k) && wlog_d[wbase+k] == ewd(v, k), rq, "write addr/data",
          {wlog_a[wbase+k], wlog_d[wbase+k]}, {ewa(v, k), ewd(v, k)});
    if (e) chk(wlog_a[wbase+nw] == AW'(16'h5555) && wlog_d[wbase+nw] == 8'hF0, "R8", "exit write",
               {wlog_a[wbase+nw], wlog_d[wbase+nw]}, {AW'(16'h5555), 8'hF0});
    chk(rcnt - rbase == nr, v.mode ? "R5" : "R4", "read count (R6 confirm)", rcnt - rbase, nr);
    chk(first_rd_w == nw, "R3", "writes before first read", first_rd_w, nw);
    chk(rd_addr_last == v.adr, "R3", "poll address", rd_addr_last, v.adr);
    chk(rd_value == mval(v, nr - 1), "R7", "rd_value", rd_value, mval(v, nr - 1));
    @(negedge clk);
    ndone = done;
    chk(ndone == 0 && busy == 0, "R7", "done one cycle", ndone, 0);
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      finished = 1;
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    cur = VEC[0];
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && err == 0 && fl_we == 0 && fl_re == 0, "R10", "held in reset",
        {busy, done, err, fl_we, fl_re}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && done == 0 && fl_we == 0 && fl_re == 0, "R10", "after reset",
        {busy, done, fl_we, fl_re}, 0);
    for (int i = 0; i < NV; i++) run(VEC[i], 1'b0);
    // R9: second start while busy must not disturb the program sequence
    run(VEC[0], 1'b1);
    // R10: reset mid-sequence
    @(negedge clk);
    cur = VEC[2]; op = 2'd1; addr = 20'h1000; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(busy == 0 && fl_we == 0 && fl_re == 0 && done == 0, "R10", "reset mid-op",
        {busy, fl_we, fl_re, done}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy == 0 && fl_we == 0, "R10", "stays idle after reset", {busy, fl_we}, 0);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule